// File: doc/BRIEF.md
# Phase-Adjustable Carrier Divider

This block turns an externally supplied carrier clock into a slower square wave. A 16-bit up-counter runs on the carrier clock and wraps to zero at the end of each period. Two compare points control the output: a "set" point raises it and a "clear" point lowers it.

Software on a separate host clock has three registers. It can load a new divisor, which also recentres the two compare points for a near-even duty cycle. It can shift both compare points by a signed step, modulo the period, to slide the output phase without changing its shape. It can gate the counter and request a restart from zero.

Host updates cross into the carrier domain as one bundle through a toggle handshake. The carrier side holds new compare values back until the current period wraps, so a run-time phase nudge can never produce a runt pulse.

Top module: `cdiv_top`

## Requirements
- R1: After reset the host reads period 128 (read address 0), set point 0 (read address 1), enable 1 (read address 2, bit 0) and clear point 64 (read address 3). The carrier count is 0 and the output is low.
- R2: While enabled, the carrier count steps by one on each carrier clock edge from 0 to period-1, then returns to 0.
- R3: The output rises on the carrier edge after the count equals the set point, and falls on the edge after the count equals the clear point. So the count seen beside a rising output is (set+1) mod period, and beside a falling output it is (clear+1) mod period.
- R4: A write to address 0 with a value d of 2 or more makes the period d, the set point 0 and the clear point d>>1.
- R5: A write to address 1 treats the data as a signed 16-bit step s. Each compare point x becomes (x+s) mod period, always in 0..period-1, with a negative remainder lifted by adding the period.
- R6: A divisor write of 0 or 1 behaves as a write of 2.
- R7: Writing address 2 with bit 0 clear stops the count and holds the output level. Writing it with bit 0 set lets counting resume.
- R8: Writing address 2 with bit 1 set restarts the count at 0, whether or not counting is enabled. The new enable value in bit 0 is applied at the same time.
- R9: New period and compare values reach the carrier side only at a period wrap or at a restart. Until then, the running period completes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host register clock |
| car_clk | input | 1 | Carrier clock that drives the counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Host write strobe, one host cycle per write |
| wr_addr | input | 2 | Write address: 0 divisor, 1 phase step, 2 control |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 period, 1 set point, 2 control, 3 clear point |
| rd_data | output | 16 | Read data for rd_addr |
| car_count | output | 16 | Current counter value, carrier domain |
| car_div_out | output | 1 | Divided output, carrier domain |

## Verification
The bench targets phase steps whose sum is negative, or exceeds the period many times over. A design that only corrects once, or keeps the sign of the remainder, would place an edge outside the period or at the wrong count. It writes divisors 0 and 1; a design without the floor would stop toggling or run a one-count period. It nudges the phase in the middle of a long period and checks that the pending fall still happens at the old clear point. A design that applied new compares at once would move or duplicate an edge. It also restarts while gated, which a design that only restarts running counters would ignore.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam logic [1:0] WA_DIV    = 2'd0;
  localparam logic [1:0] WA_PHASE  = 2'd1;
  localparam logic [1:0] WA_CTRL   = 2'd2;
  localparam logic [1:0] RA_PERIOD = 2'd0;
  localparam logic [1:0] RA_SET    = 2'd1;
  localparam logic [1:0] RA_CTRL   = 2'd2;
  localparam logic [1:0] RA_CLR    = 2'd3;
  localparam int CTRL_EN      = 0;
  localparam int CTRL_RESTART = 1;
endpackage

// File: rtl/cdiv_rst_sync.sv
module cdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/cdiv_xfer.sv
module cdiv_xfer #(
  parameter int PW = 50
) (
  input  logic          src_clk,
  input  logic          src_rst_n,
  input  logic          launch,
  input  logic [PW-1:0] src_data,
  output logic          busy,
  input  logic          dst_clk,
  input  logic          dst_rst_n,
  output logic          dst_stb,
  output logic [PW-1:0] dst_data
);
  logic          req_q;
  logic [PW-1:0] hold_q;
  logic          ack_s1_q, ack_s2_q;
  logic          rq_s1_q, rq_s2_q, rq_s3_q;

  // source side: capture the bundle and flip the request toggle
  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else if (launch) begin
      req_q  <= ~req_q;
      hold_q <= src_data;
    end
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      ack_s1_q <= 1'b0;
      ack_s2_q <= 1'b0;
    end else begin
      ack_s1_q <= rq_s3_q;
      ack_s2_q <= ack_s1_q;
    end
  end

  // destination side: two-flop sync plus edge detect
  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      rq_s1_q <= 1'b0;
      rq_s2_q <= 1'b0;
      rq_s3_q <= 1'b0;
    end else begin
      rq_s1_q <= req_q;
      rq_s2_q <= rq_s1_q;
      rq_s3_q <= rq_s2_q;
    end
  end

  assign busy     = req_q ^ ack_s2_q;
  assign dst_stb  = rq_s2_q ^ rq_s3_q;
  assign dst_data = hold_q;
endmodule

// File: rtl/cdiv_host_regs.sv
module cdiv_host_regs
  import cdiv_pkg::*;
#(
  parameter int          DW      = 16,
  parameter int          DEF_DIV = 128,
  parameter logic        DEF_EN  = 1'b1,
  localparam int         PW      = 3 * DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          busy,
  output logic          launch,
  output logic [PW-1:0] payload,
  output logic [DW-1:0] sh_p,
  output logic [DW-1:0] sh_a,
  output logic [DW-1:0] sh_b
);
  localparam logic [DW-1:0] MIN_P = DW'(2);
  localparam logic [DW-1:0] DEF_P = DW'(DEF_DIV);

  logic [DW-1:0] p_q, a_q, b_q, p_d, a_d, b_d;
  logic          en_q, en_d, rs_q, rs_d, dirty_q, dirty_d;

  // (base + signed step) mod per, result in 0..per-1
  function automatic logic [DW-1:0] mod_add(input logic [DW-1:0] base,
                                            input logic [DW-1:0] step,
                                            input logic [DW-1:0] per);
    logic signed [DW+1:0] sum, rem, pr;
    pr  = $signed({2'b00, per});
    sum = $signed({2'b00, base}) + $signed({{2{step[DW-1]}}, step});
    rem = sum % pr;
    if (rem < 0) rem = rem + pr;
    return rem[DW-1:0];
  endfunction

  assign launch = dirty_q && !busy;

  always_comb begin
    p_d     = p_q;
    a_d     = a_q;
    b_d     = b_q;
    en_d    = en_q;
    rs_d    = rs_q;
    dirty_d = dirty_q;
    if (launch) begin
      dirty_d = 1'b0;
      rs_d    = 1'b0;
    end
    if (wr_en) begin
      case (wr_addr)
        WA_DIV: begin
          p_d     = (wr_data < MIN_P) ? MIN_P : wr_data;
          a_d     = '0;
          b_d     = p_d >> 1;
          dirty_d = 1'b1;
        end
        WA_PHASE: begin
          a_d     = mod_add(a_q, wr_data, p_q);
          b_d     = mod_add(b_q, wr_data, p_q);
          dirty_d = 1'b1;
        end
        WA_CTRL: begin
          en_d    = wr_data[CTRL_EN];
          if (wr_data[CTRL_RESTART]) rs_d = 1'b1;
          dirty_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q     <= DEF_P;
      a_q     <= '0;
      b_q     <= DEF_P >> 1;
      en_q    <= DEF_EN;
      rs_q    <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      p_q     <= p_d;
      a_q     <= a_d;
      b_q     <= b_d;
      en_q    <= en_d;
      rs_q    <= rs_d;
      dirty_q <= dirty_d;
    end
  end

  always_comb begin
    case (rd_addr)
      RA_PERIOD: rd_data = p_q;
      RA_SET:    rd_data = a_q;
      RA_CTRL:   rd_data = {{(DW-1){1'b0}}, en_q};
      default:   rd_data = b_q;
    endcase
  end

  assign payload = {rs_q, en_q, p_q, a_q, b_q};
  assign sh_p    = p_q;
  assign sh_a    = a_q;
  assign sh_b    = b_q;
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core #(
  parameter int   DW      = 16,
  parameter int   DEF_DIV = 128,
  parameter logic DEF_EN  = 1'b1,
  localparam int  PW      = 3 * DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic [PW-1:0] pay,
  output logic [DW-1:0] cnt,
  output logic          out,
  output logic          en,
  output logic [DW-1:0] act_p,
  output logic [DW-1:0] act_a,
  output logic [DW-1:0] act_b,
  output logic          wrap,
  output logic          rst_apply
);
  localparam logic [DW-1:0] DEF_P = DW'(DEF_DIV);

  logic          pay_rs, pay_en;
  logic [DW-1:0] pay_p, pay_a, pay_b;
  logic [DW-1:0] cnt_q, cnt_d, p_q, a_q, b_q, p_d, a_d, b_d;
  logic [DW-1:0] pp_q, pa_q, pb_q, pp_d, pa_d, pb_d;
  logic          pv_q, pv_d, en_q, en_d, out_q, out_d;
  logic          src_v, take;
  logic [DW-1:0] src_p, src_a, src_b;

  assign {pay_rs, pay_en, pay_p, pay_a, pay_b} = pay;

  assign wrap      = en_q && (cnt_q >= p_q - DW'(1));
  assign rst_apply = stb && pay_rs;
  assign take      = wrap || rst_apply;

  // a fresh arrival overrides an older pending bundle
  assign src_v = stb || pv_q;
  assign src_p = stb ? pay_p : pp_q;
  assign src_a = stb ? pay_a : pa_q;
  assign src_b = stb ? pay_b : pb_q;

  always_comb begin
    cnt_d = cnt_q;
    p_d   = p_q;
    a_d   = a_q;
    b_d   = b_q;
    pp_d  = pp_q;
    pa_d  = pa_q;
    pb_d  = pb_q;
    pv_d  = pv_q;
    en_d  = stb ? pay_en : en_q;
    out_d = out_q;
    if (rst_apply || wrap) cnt_d = '0;
    else if (en_q)         cnt_d = cnt_q + DW'(1);
    if (take) begin
      pv_d = 1'b0;
      if (src_v) begin
        p_d = src_p;
        a_d = src_a;
        b_d = src_b;
      end
    end else if (stb) begin
      pp_d = pay_p;
      pa_d = pay_a;
      pb_d = pay_b;
      pv_d = 1'b1;
    end
    if (en_q) begin
      if (cnt_q == b_q)      out_d = 1'b0;   // clear has priority
      else if (cnt_q == a_q) out_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      p_q   <= DEF_P;
      a_q   <= '0;
      b_q   <= DEF_P >> 1;
      pp_q  <= '0;
      pa_q  <= '0;
      pb_q  <= '0;
      pv_q  <= 1'b0;
      en_q  <= DEF_EN;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      p_q   <= p_d;
      a_q   <= a_d;
      b_q   <= b_d;
      pp_q  <= pp_d;
      pa_q  <= pa_d;
      pb_q  <= pb_d;
      pv_q  <= pv_d;
      en_q  <= en_d;
      out_q <= out_d;
    end
  end

  assign cnt   = cnt_q;
  assign out   = out_q;
  assign en    = en_q;
  assign act_p = p_q;
  assign act_a = a_q;
  assign act_b = b_q;
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top #(
  parameter int   DW      = 16,
  parameter int   DEF_DIV = 128,
  parameter logic DEF_EN  = 1'b1
) (
  input  logic          host_clk,
  input  logic          car_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] car_count,
  output logic          car_div_out
);
  localparam int PW = 3 * DW + 2;

  logic          host_rst_n, car_rst_n;
  logic          busy, launch, stb;
  logic [PW-1:0] h_pay, c_pay;
  logic [DW-1:0] sh_p, sh_a, sh_b;
  logic [DW-1:0] act_p, act_a, act_b;
  logic          c_en, c_wrap, c_rst_apply;

  cdiv_rst_sync u_hrst (.clk(host_clk), .rst_n(rst_n), .rst_sync_n(host_rst_n));
  cdiv_rst_sync u_crst (.clk(car_clk),  .rst_n(rst_n), .rst_sync_n(car_rst_n));

  cdiv_host_regs #(.DW(DW), .DEF_DIV(DEF_DIV), .DEF_EN(DEF_EN)) u_regs (
    .clk(host_clk), .rst_n(host_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .launch(launch), .payload(h_pay),
    .sh_p(sh_p), .sh_a(sh_a), .sh_b(sh_b)
  );

  cdiv_xfer #(.PW(PW)) u_xfer (
    .src_clk(host_clk), .src_rst_n(host_rst_n), .launch(launch),
    .src_data(h_pay), .busy(busy),
    .dst_clk(car_clk), .dst_rst_n(car_rst_n), .dst_stb(stb), .dst_data(c_pay)
  );

  cdiv_core #(.DW(DW), .DEF_DIV(DEF_DIV), .DEF_EN(DEF_EN)) u_core (
    .clk(car_clk), .rst_n(car_rst_n), .stb(stb), .pay(c_pay),
    .cnt(car_count), .out(car_div_out), .en(c_en),
    .act_p(act_p), .act_a(act_a), .act_b(act_b),
    .wrap(c_wrap), .rst_apply(c_rst_apply)
  );
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
  parameter int DW = 16
) (
  input logic          car_clk,
  input logic          car_rst_n,
  input logic          host_clk,
  input logic          host_rst_n,
  input logic [DW-1:0] cnt,
  input logic          out,
  input logic          en,
  input logic [DW-1:0] act_p,
  input logic [DW-1:0] act_a,
  input logic [DW-1:0] act_b,
  input logic          wrap,
  input logic          rst_apply,
  input logic [DW-1:0] sh_p,
  input logic [DW-1:0] sh_a,
  input logic [DW-1:0] sh_b
);
  a_r2_count_in_period: assert property (@(posedge car_clk) disable iff (!car_rst_n)
    cnt < act_p);

  a_r3_set_point: assert property (@(posedge car_clk) disable iff (!car_rst_n)
    (en && cnt == act_a && cnt != act_b) |=> out);

  a_r3_clear_point: assert property (@(posedge car_clk) disable iff (!car_rst_n)
    (en && cnt == act_b) |=> !out);

  a_r5_host_phase_range: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    (sh_a < sh_p) && (sh_b < sh_p));

  a_r6_min_period: assert property (@(posedge car_clk) disable iff (!car_rst_n)
    act_p >= DW'(2));

  a_r7_frozen: assert property (@(posedge car_clk) disable iff (!car_rst_n)
    (!en && !rst_apply) |=> ($stable(cnt) && $stable(out)));

  a_r9_update_at_wrap: assert property (@(posedge car_clk) disable iff (!car_rst_n)
    (!wrap && !rst_apply) |=> ($stable(act_p) && $stable(act_a) && $stable(act_b)));
endmodule

bind cdiv_top cdiv_checker #(.DW(DW)) u_chk (
  .car_clk(car_clk), .car_rst_n(car_rst_n),
  .host_clk(host_clk), .host_rst_n(host_rst_n),
  .cnt(car_count), .out(car_div_out), .en(c_en),
  .act_p(act_p), .act_a(act_a), .act_b(act_b),
  .wrap(c_wrap), .rst_apply(c_rst_apply),
  .sh_p(sh_p), .sh_a(sh_a), .sh_b(sh_b)
);

// File: tb/cdiv_top_tb_top.sv
`timescale 1ns/1ps
module cdiv_top_tb_top;
  logic        hclk, cclk, rst_n, wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data, count;
  logic        dout;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  cdiv_top dut_i (
    .host_clk(hclk), .car_clk(cclk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .car_count(count), .car_div_out(dout)
  );

  initial hclk = 1'b0;
  always #10 hclk = ~hclk;
  initial cclk = 1'b0;
  always #37 cclk = ~cclk;

  // op, data, expected period, set point, clear point
  localparam logic [65:0] VEC [12] = '{
    {2'd0, 16'd10,    16'd10, 16'd0, 16'd5},
    {2'd1, 16'd3,     16'd10, 16'd3, 16'd8},
    {2'd1, 16'hFFFB,  16'd10, 16'd8, 16'd3},
    {2'd1, 16'd25,    16'd10, 16'd3, 16'd8},
    {2'd0, 16'd7,     16'd7,  16'd0, 16'd3},
    {2'd1, 16'hFFF0,  16'd7,  16'd5, 16'd1},
    {2'd0, 16'd1,     16'd2,  16'd0, 16'd1},
    {2'd0, 16'd0,     16'd2,  16'd0, 16'd1},
    {2'd0, 16'd3,     16'd3,  16'd0, 16'd1},
    {2'd0, 16'd9,     16'd9,  16'd0, 16'd4},
    {2'd1, 16'h7FFF,  16'd9,  16'd7, 16'd2},
    {2'd1, 16'h8000,  16'd9,  16'd8, 16'd3}
  };

  // carrier-side monitor, sampled mid-cycle
  logic mon_arm = 1'b0;
  logic prev_o  = 1'b0;
  int   rise_c, fall_c, max_c;
  always @(negedge cclk) begin
    if (!mon_arm) begin
      rise_c = -1; fall_c = -1; max_c = -1;
    end else begin
      if (dout && !prev_o) rise_c = int'(count);
      if (!dout && prev_o) fall_c = int'(count);
      if (int'(count) > max_c) max_c = int'(count);
    end
    prev_o = dout;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] ad, input logic [15:0] d);
    @(negedge hclk);
    wr_en = 1'b1; wr_addr = ad; wr_data = d;
    @(negedge hclk);
    wr_en = 1'b0;
  endtask

  task automatic hread(input logic [1:0] ad, output int v);
    @(negedge hclk);
    rd_addr = ad;
    #1 v = int'(rd_data);
  endtask

  task automatic cwait(input int n);
    repeat (n) @(posedge cclk);
  endtask

  task automatic observe(input int n, output int rc, output int fc, output int mc);
    @(posedge cclk);
    mon_arm = 1'b1;
    repeat (n) @(posedge cclk);
    #1;
    rc = rise_c; fc = fall_c; mc = max_c;
    mon_arm = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int v, rc, fc, mc, prev_p, snap_c, snap_o, found;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(negedge hclk);
    rst_n = 1'b1;
    #1;
    chk("R1", "count after reset", int'(count), 0);
    chk("R1", "output after reset", int'(dout), 0);
    hread(2'd0, v); chk("R1", "period", v, 128);
    hread(2'd1, v); chk("R1", "set point", v, 0);
    hread(2'd3, v); chk("R1", "clear point", v, 64);
    hread(2'd2, v); chk("R1", "enable", v, 1);
    cwait(8);
    observe(2 * 128 + 6, rc, fc, mc);
    chk("R3", "default rise count", rc, 1);
    chk("R3", "default fall count", fc, 65);
    chk("R2", "default max count", mc, 127);
    prev_p = 128;

    // table of divisor and phase writes
    for (int i = 0; i < 12; i++) begin
      logic [1:0]  op;
      logic [15:0] d;
      int p, a, b;
      string tag;
      op = VEC[i][65:64]; d = VEC[i][63:48];
      p = int'(VEC[i][47:32]); a = int'(VEC[i][31:16]); b = int'(VEC[i][15:0]);
      tag = (op == 2'd1) ? "R5" : ((d < 16'd2) ? "R6" : "R4");
      hwrite(op, d);
      cwait(((prev_p > p) ? prev_p : p) + 12);
      hread(2'd0, v); chk(tag, "period readback", v, p);
      hread(2'd1, v); chk(tag, "set readback", v, a);
      hread(2'd3, v); chk(tag, "clear readback", v, b);
      observe(2 * p + 6, rc, fc, mc);
      chk("R3", "rise count", rc, (a + 1) % p);
      chk("R3", "fall count", fc, (b + 1) % p);
      chk("R2", "max count", mc, p - 1);
      prev_p = p;
    end

    // R7: gating freezes count and output
    hwrite(2'd2, 16'd0);
    cwait(10);
    #1; snap_c = int'(count); snap_o = int'(dout);
    cwait(30);
    #1;
    chk("R7", "frozen count", int'(count), snap_c);
    chk("R7", "frozen output", int'(dout), snap_o);
    hread(2'd2, v); chk("R7", "enable readback", v, 0);

    // R8: restart while gated
    hwrite(2'd2, 16'd2);
    cwait(10);
    #1; chk("R8", "count after gated restart", int'(count), 0);
    cwait(10);
    #1; chk("R8", "count stays at zero while gated", int'(count), 0);
    hwrite(2'd2, 16'd1);
    cwait(10);
    #1; chk("R7", "counting resumes", int'(count != 16'd0), 1);

    // R9: phase nudge mid-period takes effect only at the wrap
    hwrite(2'd0, 16'd40);
    cwait(60);
    found = 0;
    for (int k = 0; k < 100 && found == 0; k++) begin
      @(posedge cclk); #1;
      if (count == 16'd2) found = 1;
    end
    chk("R9", "reached count 2", found, 1);
    hwrite(2'd1, 16'd10);
    found = -1;
    for (int k = 0; k < 60 && found < 0; k++) begin
      @(posedge cclk); #1;
      if (!dout) found = int'(count);
    end
    chk("R9", "first fall uses old clear point", found, 21);
    found = -1;
    for (int k = 0; k < 60 && found < 0; k++) begin
      @(posedge cclk); #1;
      if (dout) found = int'(count);
    end
    chk("R9", "next rise uses new set point", found, 11);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule